// File: doc/BRIEF.md
# Dual-Bank GPIO Controller with Set/Clear Writes

This block controls 32 general-purpose pins, arranged as two banks of 16, through a small single-cycle register bus. Every per-pin control register is written in a paired format. The low half of the write word sets pins and the high half clears them. Software can therefore change any group of pins with one write, without a read-modify-write. Bank 1 has the same register layout as bank 0, shifted up by 0x80.

Each pin has an output value, an output enable, an input enable, two auxiliary output selects and an auxiliary input select. When a pin drives, its level comes from auxiliary input 1, auxiliary input 2 or the output value bit. Pad inputs pass through a two-flop synchronizer. From there they feed a level read-back register and two edge status registers, one for rising and one for falling edges. Edge flags are cleared by writing ones to the status register.

Top module: `gpio_dual_bank`

## Requirements
- R1: In a write to a control register, a 1 in bit n (n = 0..15) sets pin n of the addressed bank, a 1 in bit n+16 clears it, and pins whose two bits are both 0 keep their state.
- R2: When one write has both the set bit and the clear bit of the same pin, that pin ends up cleared.
- R3: Byte offsets within a bank are: output value 0x00, output enable 0x04, input enable 0x08, aux-1 output select 0x0C, aux-2 output select 0x10, aux input select 0x14, level read-back 0x18, rising-edge status 0x1C, falling-edge status 0x20. Bank 1 (pins 16..31) is at the same offsets plus 0x80. A read returns pin (p mod 16) in bit p mod 16, and bits 31:16 read as 0. Read data appears on the bus output one clock after the address.
- R4: pad_oe follows the output enable bit. A driving pad outputs aux1_in when its aux-1 select is 1. Otherwise it outputs aux2_in when its aux-2 select is 1. Otherwise it outputs the output value bit. pad_out is 0 wherever the pad does not drive.
- R5: pad_in passes through two flops. The read-back of a pin shows the synchronized level while its input enable or output enable is 1, so an output pin reads its own level. With both enables at 0 the pin reads 0.
- R6: A pin whose input is enabled (as in R5) sets its rising flag when its synchronized level goes from 0 to 1, and its falling flag when it goes from 1 to 0. A pin whose input is disabled records no edges.
- R7: Writing to a status register clears each flag whose low-half bit is 1. Bits 31:16 of such a write have no effect.
- R8: When a new edge and a clear of the same flag fall in the same cycle, the flag ends up set.
- R9: Pins 23, 29, 30 and 31 are reserved. Their control bits cannot be set, they never drive their pad, and they read 0 in every register.
- R10: Unmapped addresses read as 0. Writes to the read-back offset change nothing.
- R11: After reset every control and status bit is 0, no pad drives, and the read data is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data: set bits 15:0, clear bits 31:16 |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Pad input levels (asynchronous) |
| aux1_in | input | 32 | Auxiliary output source 1, per pin |
| aux2_in | input | 32 | Auxiliary output source 2, per pin |
| pad_out | output | 32 | Driven pad level |
| pad_oe | output | 32 | Pad drive enable |

## Verification
Two events can land on the same status flag in the same cycle: a freshly synchronized edge and a software clear written to that flag. The bench raises a pad at a falling clock edge. It counts the two synchronizer stages and places the clear write in the exact cycle in which the edge is recognised. In that same write it also clears a second flag that was already latched. The racing flag must read back as 1 and the second flag as 0. This shows that the clear acted in that cycle and that the new edge still won.

// File: rtl/gpio_dual_bank.sv
module gpio_dual_bank #(
  parameter int BANK_W = 16,
  parameter int ADDR_W = 8,
  parameter int BANK_OFS = 128,
  parameter logic [2*BANK_W-1:0] RSVD = 32'hE080_0000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_wr,
  input  logic [2*BANK_W-1:0] bus_wdata,
  output logic [2*BANK_W-1:0] bus_rdata,
  input  logic [2*BANK_W-1:0] pad_in,
  input  logic [2*BANK_W-1:0] aux1_in,
  input  logic [2*BANK_W-1:0] aux2_in,
  output logic [2*BANK_W-1:0] pad_out,
  output logic [2*BANK_W-1:0] pad_oe
);
  localparam int NPIN = 2 * BANK_W;
  localparam logic [ADDR_W-1:0] O_OV  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] O_OE  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] O_IE  = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] O_AX1 = ADDR_W'(12);
  localparam logic [ADDR_W-1:0] O_AX2 = ADDR_W'(16);
  localparam logic [ADDR_W-1:0] O_AXI = ADDR_W'(20);
  localparam logic [ADDR_W-1:0] O_RB  = ADDR_W'(24);
  localparam logic [ADDR_W-1:0] O_POS = ADDR_W'(28);
  localparam logic [ADDR_W-1:0] O_NEG = ADDR_W'(32);

  logic [NPIN-1:0] r_ov, r_oe, r_ie, r_ax1, r_ax2, r_axi;
  logic [NPIN-1:0] st_pos, st_neg, sync1, sync2, lvl_q;

  logic              bank;
  logic [ADDR_W-1:0] ofs;
  assign bank = bus_addr >= ADDR_W'(BANK_OFS);
  assign ofs  = bank ? bus_addr - ADDR_W'(BANK_OFS) : bus_addr;

  logic [NPIN-1:0] set_v, clr_v;
  assign set_v = {{BANK_W{1'b0}}, bus_wdata[BANK_W-1:0]} << (bank ? BANK_W : 0);
  assign clr_v = {{BANK_W{1'b0}}, bus_wdata[NPIN-1:BANK_W]} << (bank ? BANK_W : 0);

  function automatic logic [NPIN-1:0] apply(input logic [NPIN-1:0] old,
                                            input logic [NPIN-1:0] s,
                                            input logic [NPIN-1:0] c);
    return (old | s) & ~c & ~RSVD;
  endfunction

  logic wr_ov, wr_oe, wr_ie, wr_ax1, wr_ax2, wr_axi, wr_pos, wr_neg;
  assign wr_ov  = bus_wr && ofs == O_OV;
  assign wr_oe  = bus_wr && ofs == O_OE;
  assign wr_ie  = bus_wr && ofs == O_IE;
  assign wr_ax1 = bus_wr && ofs == O_AX1;
  assign wr_ax2 = bus_wr && ofs == O_AX2;
  assign wr_axi = bus_wr && ofs == O_AXI;
  assign wr_pos = bus_wr && ofs == O_POS;
  assign wr_neg = bus_wr && ofs == O_NEG;

  logic [NPIN-1:0] in_en, rise, fall, rb_val;
  assign in_en  = (r_ie | r_oe) & ~RSVD;
  assign rise   = sync2 & ~lvl_q & in_en;
  assign fall   = ~sync2 & lvl_q & in_en;
  assign rb_val = sync2 & in_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_ov <= '0; r_oe <= '0; r_ie <= '0;
      r_ax1 <= '0; r_ax2 <= '0; r_axi <= '0;
      st_pos <= '0; st_neg <= '0;
      sync1 <= '0; sync2 <= '0; lvl_q <= '0;
    end else begin
      if (wr_ov)  r_ov  <= apply(r_ov,  set_v, clr_v);
      if (wr_oe)  r_oe  <= apply(r_oe,  set_v, clr_v);
      if (wr_ie)  r_ie  <= apply(r_ie,  set_v, clr_v);
      if (wr_ax1) r_ax1 <= apply(r_ax1, set_v, clr_v);
      if (wr_ax2) r_ax2 <= apply(r_ax2, set_v, clr_v);
      if (wr_axi) r_axi <= apply(r_axi, set_v, clr_v);
      st_pos <= ((st_pos & ~(wr_pos ? set_v : '0)) | rise) & ~RSVD;
      st_neg <= ((st_neg & ~(wr_neg ? set_v : '0)) | fall) & ~RSVD;
      sync1 <= pad_in;
      sync2 <= sync1;
      lvl_q <= sync2;
    end
  end

  logic [NPIN-1:0] drv;
  assign drv     = (r_ax1 & aux1_in) | (~r_ax1 & r_ax2 & aux2_in) | (~r_ax1 & ~r_ax2 & r_ov);
  assign pad_oe  = r_oe;
  assign pad_out = r_oe & drv;

  logic            mapped;
  logic [NPIN-1:0] rd_v;
  always_comb begin
    mapped = 1'b1;
    unique case (ofs)
      O_OV:    rd_v = r_ov;
      O_OE:    rd_v = r_oe;
      O_IE:    rd_v = r_ie;
      O_AX1:   rd_v = r_ax1;
      O_AX2:   rd_v = r_ax2;
      O_AXI:   rd_v = r_axi;
      O_RB:    rd_v = rb_val;
      O_POS:   rd_v = st_pos;
      O_NEG:   rd_v = st_neg;
      default: begin rd_v = '0; mapped = 1'b0; end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= {{BANK_W{1'b0}}, rd_v[(bank ? BANK_W : 0) +: BANK_W]};
  end

  a_r1_zero_write_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ov && bus_wdata == '0) |=> $stable(r_ov));
  a_r2_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_oe |=> (r_oe & $past(set_v & clr_v)) == '0);
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[NPIN-1:BANK_W] == '0);
  a_r6_no_edge_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((st_pos | st_neg) & ~$past(st_pos | st_neg) & ~$past(in_en)) == '0);
  a_r8_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pos && (rise & set_v) != '0) |=> (st_pos & $past(rise)) == $past(rise));
  a_r9_reserved_idle: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe | st_pos | st_neg | r_ie) & RSVD) == '0);
  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !mapped |=> bus_rdata == '0);
endmodule

// File: tb/gpio_dual_bank_test.sv
module gpio_dual_bank_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  bus_addr = 0;
  logic        bus_wr = 0;
  logic [31:0] bus_wdata = 0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = 0, aux1_in = 0, aux2_in = 0;
  logic [31:0] pad_out, pad_oe;
  int checks = 0, failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  gpio_dual_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .aux1_in(aux1_in), .aux2_in(aux2_in), .pad_out(pad_out), .pad_oe(pad_oe));

  localparam logic [7:0] OV = 8'h00, OE = 8'h04, IE = 8'h08, AX1 = 8'h0C, AX2 = 8'h10,
                         AXI = 8'h14, RB = 8'h18, POS = 8'h1C, NEG = 8'h20, B1 = 8'h80;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wr = 0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R11 rdata", bus_rdata, 0);
    check("R11 pad_oe", pad_oe, 0);
    rd(OE, d); check("R11 oe reg", d, 0);
    rd(B1 + POS, d); check("R11 pos status", d, 0);
  endtask

  task automatic t_setclr;
    logic [31:0] d;
    wr(OV, 32'h0000_00F0);
    rd(OV, d); check("R1 set", d, 32'h00F0);
    wr(OV, 32'h0030_0001);
    rd(OV, d); check("R1 clear and set", d, 32'h00C1);
    wr(OV, 32'h0);
    rd(OV, d); check("R1 zero write keeps", d, 32'h00C1);
    wr(OV, 32'h0041_0041);
    rd(OV, d); check("R2 clear priority", d, 32'h0080);
  endtask

  task automatic t_bank1;
    logic [31:0] d;
    wr(B1 + AXI, 32'h0000_0005);
    rd(B1 + AXI, d); check("R3 bank1 layout", d, 32'h0005);
    rd(AXI, d); check("R3 bank0 untouched", d, 0);
    wr(B1 + AXI, 32'h0001_0000);
    rd(B1 + AXI, d); check("R3 bank1 clear", d, 32'h0004);
  endtask

  task automatic t_drive;
    wr(OV, 32'h00FF_0000);
    wr(OV, 32'h0000_0004);
    check("R4 no drive without oe", pad_out & 32'h4, 0);
    wr(OE, 32'h0000_0004);
    check("R4 oe pin2", pad_oe, 32'h4);
    check("R4 drives ov", pad_out, 32'h4);
    aux2_in = 0; aux1_in = 32'h4;
    wr(AX2, 32'h0000_0004);
    #1 check("R4 aux2 source", pad_out, 0);
    wr(AX1, 32'h0000_0004);
    #1 check("R4 aux1 over aux2", pad_out, 32'h4);
    aux1_in = 0;
    #1 check("R4 aux1 follows", pad_out, 0);
    wr(OE, 32'h0004_0000);
    wr(AX1, 32'h0004_0000);
    wr(AX2, 32'h0004_0000);
  endtask

  task automatic t_readback;
    logic [31:0] d;
    pad_in = 32'h0000_0300;
    idle(4);
    rd(RB, d); check("R5 disabled reads 0", d, 0);
    wr(IE, 32'h0000_0100);
    wr(OE, 32'h0000_0200);
    idle(1);
    rd(RB, d); check("R5 ie and oe pins", d, 32'h0300);
    @(negedge clk) pad_in = 0;
    @(negedge clk);
    check("R5 two-flop delay", 32'(bus_rdata), 32'h0300);
    idle(3);
    rd(RB, d); check("R5 follows low", d, 0);
    wr(OE, 32'h0200_0000);
    wr(IE, 32'h0100_0000);
  endtask

  task automatic t_edges;
    logic [31:0] d;
    wr(IE, 32'h0000_0020);
    wr(POS, 32'h0000_FFFF);
    wr(NEG, 32'h0000_FFFF);
    @(negedge clk) pad_in = 32'h0000_0060;
    idle(4);
    rd(POS, d); check("R6 rise enabled only", d, 32'h0020);
    rd(NEG, d); check("R6 no fall yet", d, 0);
    @(negedge clk) pad_in = 0;
    idle(4);
    rd(NEG, d); check("R6 fall flagged", d, 32'h0020);
    wr(POS, 32'hFFFF_0000);
    rd(POS, d); check("R7 high half ignored", d, 32'h0020);
    wr(POS, 32'h0000_0020);
    rd(POS, d); check("R7 clear by one", d, 0);
    rd(NEG, d); check("R7 other status kept", d, 32'h0020);
  endtask

  task automatic t_race;
    logic [31:0] d;
    wr(B1 + IE, 32'h0000_0003);
    @(negedge clk) pad_in = 32'h0001_0000;
    idle(4);
    rd(B1 + POS, d); check("R8 pre-latched pin16", d, 32'h0001);
    @(negedge clk) pad_in = 32'h0003_0000;
    @(negedge clk);
    @(negedge clk);
    bus_addr = B1 + POS; bus_wdata = 32'h0000_0003; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
    rd(B1 + POS, d); check("R8 edge wins same-cycle clear", d, 32'h0002);
  endtask

  task automatic t_reserved;
    logic [31:0] d;
    wr(B1 + OE, 32'h0000_FFFF);
    rd(B1 + OE, d); check("R9 reserved oe bits", d, 32'h1F7F);
    check("R9 reserved pads idle", pad_oe & 32'hE080_0000, 0);
    pad_in = 32'hFFFF_0000;
    idle(4);
    rd(B1 + RB, d); check("R9 reserved read 0", d, 32'h1F7F);
    rd(B1 + NEG, d); check("R9 reserved no status", d & 32'hE080, 0);
    wr(B1 + OE, 32'hFFFF_0000);
  endtask

  task automatic t_unmapped;
    logic [31:0] d;
    rd(8'h40, d); check("R10 unmapped bank0", d, 0);
    rd(8'hFC, d); check("R10 unmapped bank1", d, 0);
    pad_in = 0;
    wr(IE, 32'h0000_0100);
    pad_in = 32'h0000_0100;
    idle(4);
    wr(RB, 32'h0100_0000);
    rd(RB, d); check("R10 read-back write ignored", d, 32'h0100);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_setclr;
    t_bank1;
    t_drive;
    t_readback;
    t_edges;
    t_race;
    t_reserved;
    t_unmapped;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule